// File: doc/BRIEF.md
# Flash Block Protection Controller

This controller keeps two enable masks for a small flash array split into 2 KB blocks. One mask permits read and execute access to each block. The other permits program and erase access. Each block has one bit in each mask, and a set bit means the access is allowed. With the default four blocks, the masks cover 8 KB. Software can remove permissions but can never grant them again. A bit that software clears stays provisional until a commit strobe folds it into a retained (nonvolatile) copy of that mask.

A power-on reset reloads both live masks from their retained copies. Any clear that was not committed is therefore undone. An ordinary system reset does not touch the masks. An access checker compares each flash request against the live masks and flags a violation combinationally, in the same cycle as the request.

Top module: `fbp_ctrl`

## Requirements
- R1: After the first power-on reset, both masks read back 0x0000000F, which is the factory value with every block enabled.
- R2: A write clears each mask bit that is written as 0. A bit written as 1 keeps its value, so a cleared bit can never be set again by software.
- R3: Write data bits 31:4 have no effect, and reads always return 0 in bits 31:4.
- R4: The read/execute mask is at byte offset 0x130 and the program/erase mask is at offset 0x134. Read data appears one cycle after the address is presented. Any other offset reads as 0, and writes to any other offset change neither mask.
- R5: On power-on reset (`por` high at a clock edge), each live mask is reloaded from its retained copy, which undoes any uncommitted clear.
- R6: A one-cycle `commit` strobe ANDs the live value into the retained copy of the mask chosen by `commit_sel` (0 = read/execute, 1 = program/erase). The other mask's retained copy is unchanged. Committed clears survive every later power-on reset.
- R7: A system reset (`rst`) clears the read data register but leaves both masks unchanged.
- R8: For a valid flash request, address bits 12:11 select the block. Request kinds 0 (read) and 1 (execute) are checked against the read/execute mask. Kinds 2 (program) and 3 (erase) are checked against the program/erase mask. `fl_violation` is high in the same cycle exactly when the selected bit is 0.
- R9: `fl_violation` is low whenever `fl_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| por | input | 1 | Synchronous power-on reset, active high |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| commit | input | 1 | Commit strobe |
| commit_sel | input | 1 | Mask to commit: 0 = read/execute, 1 = program/erase |
| fl_valid | input | 1 | Flash request valid |
| fl_addr | input | 13 | Flash byte address |
| fl_kind | input | 2 | 0 read, 1 execute, 2 program, 3 erase |
| fl_violation | output | 1 | Request hits a disabled block |

## Verification
Writes, commits and power-on reloads all take effect at the clock edge where they are sampled. The bench therefore drives each of these on a falling edge and reads the result with a separate read transaction afterwards. Read data is registered, so the bench presents the address on one falling edge and samples `reg_rdata` on the next falling edge. The violation flag is combinational, so it is sampled one time unit after the request is driven, with no clock edge in between. The sweeps cover every pair of clear patterns and every pair of mask values, and for each pair of mask values they try every block, request kind and valid setting.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_EXEC  = 2'd1,
    ACC_PROG  = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_t;

  localparam int NMASK = 2;

  function automatic logic uses_prog_mask(input acc_kind_t k);
    return (k == ACC_PROG) || (k == ACC_ERASE);
  endfunction
endpackage

// File: rtl/fbp_mask_cell.sv
module fbp_mask_cell #(
  parameter int NBLK = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            por,
  input  logic            wr_en,
  input  logic [NBLK-1:0] wr_bits,
  input  logic            commit_en,
  output logic [NBLK-1:0] mask
);
  // Retained copy and live mask both start at the factory value.
  logic [NBLK-1:0] nv_q   = '1;
  logic [NBLK-1:0] live_q = '1;

  always_ff @(posedge clk) begin
    if (por)        live_q <= nv_q;
    else if (wr_en) live_q <= live_q & wr_bits;
  end

  always_ff @(posedge clk) begin
    if (commit_en) nv_q <= nv_q & live_q;
  end

  assign mask = live_q;

  // R2: outside power-on reload the live mask never gains a bit
  assert_clear_only_R2: assert property (@(posedge clk) disable iff (rst)
    !por |=> ((live_q & ~$past(live_q)) == '0));
  // R5: power-on reload takes the retained copy
  assert_por_reload_R5: assert property (@(posedge clk) disable iff (rst)
    por |=> (live_q == $past(nv_q)));
  // R6: retained copy never gains a bit and moves only on its commit
  assert_nv_monotone_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((nv_q & ~$past(nv_q)) == '0));
  assert_nv_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(nv_q));
endmodule

// File: rtl/fbp_access_chk.sv
module fbp_access_chk
  import fbp_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int BLK_LSB   = 11,
  parameter int FL_ADDR_W = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic [FL_ADDR_W-1:0] addr,
  input  logic [1:0]           kind,
  input  logic [NBLK-1:0]      re_mask,
  input  logic [NBLK-1:0]      pe_mask,
  output logic                 violation
);
  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;

  logic [BLK_W-1:0] blk;
  logic [NBLK-1:0]  sel_mask;

  assign blk       = addr[BLK_LSB +: BLK_W];
  assign sel_mask  = uses_prog_mask(acc_kind_t'(kind)) ? pe_mask : re_mask;
  assign violation = valid && !sel_mask[blk];

  // R9: no violation without a request
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !violation);
  // R8: fully enabled masks never flag
  assert_open_ok_R8: assert property (@(posedge clk) disable iff (rst)
    ((&re_mask) && (&pe_mask)) |-> !violation);
endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int          NBLK      = 4,
  parameter int          BLK_LSB   = 11,
  parameter int          FL_ADDR_W = 13,
  parameter int          REG_AW    = 12,
  parameter int          DW        = 32,
  parameter logic [11:0] RE_OFF    = 12'h130,
  parameter logic [11:0] PE_OFF    = 12'h134
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 por,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic                 commit,
  input  logic                 commit_sel,
  input  logic                 fl_valid,
  input  logic [FL_ADDR_W-1:0] fl_addr,
  input  logic [1:0]           fl_kind,
  output logic                 fl_violation
);
  localparam logic [REG_AW-1:0] OFFS [NMASK] = '{REG_AW'(RE_OFF), REG_AW'(PE_OFF)};

  logic [NBLK-1:0] masks [NMASK];
  logic [DW-1:0]   rdata_q;

  for (genvar g = 0; g < NMASK; g++) begin : g_mask
    logic hit;
    assign hit = (reg_addr == OFFS[g]);
    fbp_mask_cell #(.NBLK(NBLK)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .por       (por),
      .wr_en     (reg_we && hit),
      .wr_bits   (reg_wdata[NBLK-1:0]),
      .commit_en (commit && (commit_sel == 1'(g))),
      .mask      (masks[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || por) rdata_q <= '0;
    else if (reg_addr == OFFS[0]) rdata_q <= DW'(masks[0]);
    else if (reg_addr == OFFS[1]) rdata_q <= DW'(masks[1]);
    else rdata_q <= '0;
  end

  assign reg_rdata = rdata_q;

  fbp_access_chk #(
    .NBLK(NBLK), .BLK_LSB(BLK_LSB), .FL_ADDR_W(FL_ADDR_W)
  ) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid     (fl_valid),
    .addr      (fl_addr),
    .kind      (fl_kind),
    .re_mask   (masks[0]),
    .pe_mask   (masks[1]),
    .violation (fl_violation)
  );

  // R3: reserved read bits are always zero
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_rdata[DW-1:NBLK] == '0));
  // R4: unmapped offsets read as zero
  assert_unmapped_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != OFFS[0] && reg_addr != OFFS[1]) |=> (reg_rdata == '0));
endmodule

// File: tb/fbp_ctrl_tb.sv
`timescale 1ns/1ps
module fbp_ctrl_tb;
  localparam logic [11:0] RE = 12'h130;
  localparam logic [11:0] PE = 12'h134;

  logic clk = 1'b0;
  logic rst = 1'b0, por = 1'b0;
  logic [11:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic commit = 1'b0, commit_sel = 1'b0;
  logic fl_valid = 1'b0;
  logic [12:0] fl_addr = '0;
  logic [1:0] fl_kind = '0;
  logic fl_violation;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fbp_ctrl u_dut (
    .clk(clk), .rst(rst), .por(por), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .commit(commit),
    .commit_sel(commit_sel), .fl_valid(fl_valid), .fl_addr(fl_addr),
    .fl_kind(fl_kind), .fl_violation(fl_violation)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic por_pulse();
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b0;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic do_commit(input logic sel);
    @(negedge clk); commit = 1'b1; commit_sel = sel;
    @(negedge clk); commit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    por_pulse();
    // R1 factory state
    rd(RE, d); chk("R1 re reset", d, 32'h0F);
    rd(PE, d); chk("R1 pe reset", d, 32'h0F);

    // R2/R3/R5: every pair of clear patterns, reserved bits set on write
    for (int v = 0; v < 16; v++) begin
      for (int w = 0; w < 16; w++) begin
        por_pulse();
        wr(RE, 32'hA5A5_A5A0 | v);
        wr(RE, 32'h5A5A_5A50 | w);
        rd(RE, d); chk("R2 R3 re clear-only", d, 32'(v & w));
      end
      por_pulse();
      wr(PE, 32'hFFFF_FFF0 | v);
      rd(PE, d); chk("R2 R3 pe clear", d, 32'(v));
      rd(RE, d); chk("R4 re untouched by pe write", d, 32'h0F);
    end
    // R5 uncommitted clears restored
    por_pulse();
    rd(RE, d); chk("R5 re restored", d, 32'h0F);
    rd(PE, d); chk("R5 pe restored", d, 32'h0F);

    // R4 unmapped offsets: read zero, writes ignored
    rd(12'h138, d); chk("R4 unmapped read", d, 32'h0);
    rd(12'h131, d); chk("R4 unaligned read", d, 32'h0);
    wr(12'h12C, 32'h0); wr(12'h000, 32'h0);
    rd(RE, d); chk("R4 re after stray writes", d, 32'h0F);
    rd(PE, d); chk("R4 pe after stray writes", d, 32'h0F);

    // R8/R9 exhaustive checker sweep over mask pairs, blocks, kinds, valid
    for (int re = 0; re < 16; re++) begin
      for (int pe = 0; pe < 16; pe++) begin
        por_pulse();
        wr(RE, 32'(re)); wr(PE, 32'(pe));
        for (int b = 0; b < 4; b++) begin
          for (int k = 0; k < 4; k++) begin
            for (int vl = 0; vl < 2; vl++) begin
              logic e;
              @(negedge clk);
              fl_valid = vl[0]; fl_kind = k[1:0];
              fl_addr = 13'((b << 11) | ((b * 397 + k * 131) & 13'h7FF));
              #1;
              e = vl[0] && !(((k >= 2) ? pe : re) >> b & 1);
              chk(vl ? "R8 violation" : "R9 idle quiet", 32'(fl_violation), 32'(e));
            end
          end
        end
      end
    end
    fl_valid = 1'b0;

    // R6 commit read/execute clear; program/erase clear stays provisional
    por_pulse();
    wr(RE, 32'hFFFF_FFFB);
    wr(PE, 32'hFFFF_FFFE);
    do_commit(1'b0);
    por_pulse();
    rd(RE, d); chk("R6 committed re survives por", d, 32'h0B);
    rd(PE, d); chk("R6 uncommitted pe restored", d, 32'h0F);
    wr(RE, 32'hFFFF_FFFF);
    rd(RE, d); chk("R2 committed bit cannot be set", d, 32'h0B);
    // R6 commit program/erase
    wr(PE, 32'hFFFF_FFF7);
    do_commit(1'b1);
    wr(PE, 32'hFFFF_FFFD);
    por_pulse();
    rd(PE, d); chk("R6 pe commit then por", d, 32'h07);
    rd(RE, d); chk("R6 re retained unchanged", d, 32'h0B);

    // R7 system reset leaves masks, clears read data
    wr(RE, 32'hFFFF_FFFE);
    @(negedge clk); reg_addr = RE;
    @(negedge clk); chk("R7 pre-reset read", reg_rdata, 32'h0A);
    rst = 1'b1;
    @(negedge clk); chk("R7 rdata cleared", reg_rdata, 32'h0);
    rst = 1'b0;
    rd(RE, d); chk("R7 re kept across rst", d, 32'h0A);
    rd(PE, d); chk("R7 pe kept across rst", d, 32'h07);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule